// File: doc/BRIEF.md
# Fail-Safe Power Permit Aggregator

This block collects the hardware interlock conditions that guard a detector's power supplies. It drives one permit line for each supply subsection. Three kinds of condition feed it:
- external active-high "OK" lines, such as beam-abort requests and the cooling-plant status;
- a bank of digitised thermistor readings, arranged in groups;
- a digitised dew-point reading.

Any condition that is enabled and routed to an output pulls that output's permit low. The trip then latches until software clears it. A clear is accepted only when every enabled, routed condition is healthy.

The block works in permit mode. A low, floating or missing external line counts as a fault, and after reset every permit starts low. The permit outputs are laid out as a number of power-supply groups, each split into subsections. Each output has its own routing mask, so a partial ramp-down is possible. A first-fault register records which source caused the trip.

Software reaches the block through a small write-only register port. The port holds the source mask, the routing masks, the two thresholds, the filter length and the clear command. The mask bits of the beam-abort sources are guarded by an unlock bit.

Top module: `permit_aggregator`

## Requirements
- R1: Each permit output is low exactly when its latched trip is set. The trip is set one clock after any source is faulted, unmasked and routed to that output, so the trip decision is the OR of those conditions. Source index order is: the external lines 0..N_EXT-1, then one source per thermistor group, then dew point as the last index.
- R2: An external line that reads low is a fault. After reset all permits are low, and the first-fault register holds index 0. Nothing changes until a clear is accepted.
- R3: Each external line passes a two-flop synchroniser. Its filtered state flips only after the synchronised level has differed from it for N consecutive cycles. N is in register 4, its default is 4, and a value of 0 acts as 1.
- R4: A thermistor group is faulted when any of its channels reads strictly above the unsigned threshold in register 2. A reading equal to the threshold is healthy.
- R5: The dew-point condition is faulted when the signed reading is strictly above the signed threshold in register 3. Readings are in units of 0.1 degC, and the default threshold is -300.
- R6: Register 0 bit i set masks source i, which then trips nothing.
- R7: Register 0 bits below N_ABORT (the beam-abort sources) change only while register 1 bit 0 (unlock) is set. Writes made while it is clear leave those bits as they were, and the other mask bits still update.
- R8: Register 8+k bit i routes source i to output k, where k = group*N_SUB + subsection. The reset default routes every source to every output.
- R9: A write to register 5 with bit 0 set clears all trips and rearms the first-fault register. This happens only if no unmasked, routed source is faulted at that moment; otherwise the write is ignored.
- R10: When unarmed-to-armed capture occurs, the first-fault register takes the lowest faulted, unmasked, routed source index. It then holds that index until an accepted clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ok | input | 3 | Active-high OK lines from external sources |
| temp_data | input | 1152 | Thermistor readings, channel c in bits [c*12 +: 12] |
| dew_data | input | 12 | Signed dew-point reading, 0.1 degC units |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 12 | Register write data |
| permit | output | 4 | Permit lines, one per supply subsection |
| first_fault_valid | output | 1 | First-fault register holds a captured index |
| first_fault_idx | output | 4 | Index of the first tripping source |

## Verification
The bench builds the block with two thermistor groups of four channels and three external lines. This gives six sources, so every source index, the routing masks of all four outputs and both group thresholds can be reached in a few hundred cycles. The filter length stays at 4, so that a three-cycle dropout can be shown to be rejected. Later it is set to 0, which brings the one-cycle-filter corner case within reach. A behavioural model is compared on every cycle, and directed checks cover the locked abort mask, a clear that is refused, and equality at each threshold.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int unsigned AW = 4;
  localparam logic [AW-1:0] A_MASK   = 4'd0;
  localparam logic [AW-1:0] A_UNLOCK = 4'd1;
  localparam logic [AW-1:0] A_TTHR   = 4'd2;
  localparam logic [AW-1:0] A_DTHR   = 4'd3;
  localparam logic [AW-1:0] A_FLEN   = 4'd4;
  localparam logic [AW-1:0] A_CLEAR  = 4'd5;
  localparam logic [AW-1:0] A_ROUTE0 = 4'd8;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pa_cfg_regs.sv
module pa_cfg_regs
  import pa_pkg::*;
#(
  parameter int unsigned N_SRC    = 10,
  parameter int unsigned N_ABORT  = 2,
  parameter int unsigned N_OUT    = 4,
  parameter int unsigned TW       = 12,
  parameter int unsigned DW       = 12,
  parameter int unsigned FW       = 8,
  parameter int unsigned CW       = 12,
  parameter int unsigned TEMP_DEF = 2000,
  parameter int          DEW_DEF  = -300,
  parameter int unsigned FLEN_DEF = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [CW-1:0]               wdata,
  output logic [N_SRC-1:0]            mask_q,
  output logic [TW-1:0]               tthr_q,
  output logic signed [DW-1:0]        dthr_q,
  output logic [FW-1:0]               flen_q,
  output logic [N_OUT-1:0][N_SRC-1:0] route_q,
  output logic                        clr_req
);
  logic                        unlock_q, unlock_d;
  logic [N_SRC-1:0]            mask_d;
  logic [TW-1:0]               tthr_d;
  logic signed [DW-1:0]        dthr_d;
  logic [FW-1:0]               flen_d;
  logic [N_OUT-1:0][N_SRC-1:0] route_d;

  always_comb begin
    mask_d   = mask_q;
    unlock_d = unlock_q;
    tthr_d   = tthr_q;
    dthr_d   = dthr_q;
    flen_d   = flen_q;
    route_d  = route_q;
    clr_req  = 1'b0;
    if (we) begin
      case (addr)
        A_MASK: begin
          mask_d[N_SRC-1:N_ABORT] = wdata[N_SRC-1:N_ABORT];
          if (unlock_q) mask_d[N_ABORT-1:0] = wdata[N_ABORT-1:0];
        end
        A_UNLOCK: unlock_d = wdata[0];
        A_TTHR:   tthr_d   = wdata[TW-1:0];
        A_DTHR:   dthr_d   = $signed(wdata[DW-1:0]);
        A_FLEN:   flen_d   = wdata[FW-1:0];
        A_CLEAR:  clr_req  = wdata[0];
        default: ;
      endcase
      for (int k = 0; k < int'(N_OUT); k++) begin
        if (addr == A_ROUTE0 + AW'(k)) route_d[k] = wdata[N_SRC-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      unlock_q <= 1'b0;
      tthr_q   <= TW'(TEMP_DEF);
      dthr_q   <= DW'(DEW_DEF);
      flen_q   <= FW'(FLEN_DEF);
      route_q  <= '1;
    end else begin
      mask_q   <= mask_d;
      unlock_q <= unlock_d;
      tthr_q   <= tthr_d;
      dthr_q   <= dthr_d;
      flen_q   <= flen_d;
      route_q  <= route_d;
    end
  end

  // R7: abort mask bits frozen while unlock is clear
  p_abort_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q |=> $stable(mask_q[N_ABORT-1:0]));
endmodule

// File: rtl/pa_line_filter.sv
module pa_line_filter #(
  parameter int unsigned FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_ok,
  input  logic [FW-1:0] flen,
  output logic          fault_q
);
  logic          s1_q, s2_q;
  logic [FW-1:0] cnt_q, cnt_d;
  logic          fault_d;
  logic [FW:0]   lim, nxt;

  always_comb begin
    lim     = (flen == '0) ? (FW+1)'(1) : {1'b0, flen};
    nxt     = {1'b0, cnt_q} + (FW+1)'(1);
    fault_d = fault_q;
    cnt_d   = '0;
    if ((~s2_q) != fault_q) begin
      if (nxt >= lim) fault_d = ~s2_q;
      else            cnt_d   = nxt[FW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      cnt_q   <= '0;
      fault_q <= 1'b1;
    end else begin
      s1_q    <= line_ok;
      s2_q    <= s1_q;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  // R3: filtered state holds while it agrees with the synchronised line
  p_filter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q != fault_q) |=> $stable(fault_q));
endmodule

// File: rtl/pa_sensor_cmp.sv
module pa_sensor_cmp #(
  parameter int unsigned N_TGRP = 6,
  parameter int unsigned TCH    = 16,
  parameter int unsigned TW     = 12,
  parameter int unsigned DW     = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_TGRP*TCH*TW-1:0]  temp_data,
  input  logic [TW-1:0]             tthr,
  input  logic signed [DW-1:0]      dew_data,
  input  logic signed [DW-1:0]      dthr,
  output logic [N_TGRP-1:0]         grp_flt_q,
  output logic                      dew_flt_q
);
  logic [N_TGRP-1:0] hot;
  logic              dew_hot;

  for (genvar g = 0; g < int'(N_TGRP); g++) begin : g_grp
    logic h;
    always_comb begin
      h = 1'b0;
      for (int c = 0; c < int'(TCH); c++) begin
        if (temp_data[(g*TCH + c)*TW +: TW] > tthr) h = 1'b1;
      end
    end
    assign hot[g] = h;
  end

  assign dew_hot = (dew_data > dthr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_flt_q <= '1;
      dew_flt_q <= 1'b1;
    end else begin
      grp_flt_q <= hot;
      dew_flt_q <= dew_hot;
    end
  end

  // R4: all-zero readings can never exceed any threshold
  p_grp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_data == '0) |=> (grp_flt_q == '0));
endmodule

// File: rtl/pa_trip_core.sv
module pa_trip_core #(
  parameter int unsigned N_SRC = 10,
  parameter int unsigned N_OUT = 4,
  parameter int unsigned IW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SRC-1:0]            src_flt,
  input  logic [N_SRC-1:0]            mask,
  input  logic [N_OUT-1:0][N_SRC-1:0] route,
  input  logic                        clr_req,
  output logic [N_OUT-1:0]            trip_q,
  output logic                        ff_valid_q,
  output logic [IW-1:0]               ff_idx_q
);
  logic [N_SRC-1:0] en, any_route, blk;
  logic [N_OUT-1:0] hit, trip_d;
  logic             clr_ok, ff_valid_d;
  logic [IW-1:0]    low_idx, ff_idx_d;

  always_comb begin
    en        = src_flt & ~mask;
    any_route = '0;
    for (int k = 0; k < int'(N_OUT); k++) begin
      hit[k]    = |(en & route[k]);
      any_route = any_route | route[k];
    end
    blk    = en & any_route;
    clr_ok = clr_req && (blk == '0);
  end

  always_comb begin
    low_idx = '0;
    for (int i = int'(N_SRC) - 1; i >= 0; i--) begin
      if (blk[i]) low_idx = IW'(i);
    end
  end

  always_comb begin
    trip_d     = trip_q | hit;
    ff_valid_d = ff_valid_q;
    ff_idx_d   = ff_idx_q;
    if (clr_ok) begin
      trip_d     = '0;
      ff_valid_d = 1'b0;
    end else if (!ff_valid_q && (blk != '0)) begin
      ff_valid_d = 1'b1;
      ff_idx_d   = low_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q     <= '1;
      ff_valid_q <= 1'b0;
      ff_idx_q   <= '0;
    end else begin
      trip_q     <= trip_d;
      ff_valid_q <= ff_valid_d;
      ff_idx_q   <= ff_idx_d;
    end
  end

  // R1: a routed enabled fault sets the trip of that output
  p_trip_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((trip_q & $past(hit)) == $past(hit)));
  // R9: without an accepted clear no trip bit falls
  p_trip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_ok |=> ((trip_q & $past(trip_q)) == $past(trip_q)));
  // R9: a clear refused by a live fault leaves the first-fault record armed
  p_clr_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && (blk != '0)) |=> ff_valid_q);
  // R10: captured index is held until an accepted clear
  p_ff_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ff_valid_q && !clr_ok) |=> (ff_valid_q && $stable(ff_idx_q)));
endmodule

// File: rtl/permit_aggregator.sv
module permit_aggregator
  import pa_pkg::*;
#(
  parameter int unsigned N_EXT    = 3,
  parameter int unsigned N_ABORT  = 2,
  parameter int unsigned N_TGRP   = 6,
  parameter int unsigned TCH      = 16,
  parameter int unsigned TW       = 12,
  parameter int unsigned DW       = 12,
  parameter int unsigned FW       = 8,
  parameter int unsigned N_PSG    = 2,
  parameter int unsigned N_SUB    = 2,
  parameter int unsigned TEMP_DEF = 2000,
  parameter int          DEW_DEF  = -300,
  parameter int unsigned FLEN_DEF = 4,
  localparam int unsigned N_SRC   = N_EXT + N_TGRP + 1,
  localparam int unsigned N_OUT   = N_PSG * N_SUB,
  localparam int unsigned IW      = $clog2(N_SRC),
  localparam int unsigned CW      = max2(max2(N_SRC, TW), max2(DW, FW))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_EXT-1:0]         ext_ok,
  input  logic [N_TGRP*TCH*TW-1:0] temp_data,
  input  logic signed [DW-1:0]     dew_data,
  input  logic                     cfg_we,
  input  logic [AW-1:0]            cfg_addr,
  input  logic [CW-1:0]            cfg_wdata,
  output logic [N_OUT-1:0]         permit,
  output logic                     first_fault_valid,
  output logic [IW-1:0]            first_fault_idx
);
  logic [N_SRC-1:0]            mask_q;
  logic [TW-1:0]               tthr_q;
  logic signed [DW-1:0]        dthr_q;
  logic [FW-1:0]               flen_q;
  logic [N_OUT-1:0][N_SRC-1:0] route_q;
  logic                        clr_req;
  logic [N_EXT-1:0]            ext_flt;
  logic [N_TGRP-1:0]           grp_flt;
  logic                        dew_flt;
  logic [N_SRC-1:0]            src_flt;
  logic [N_OUT-1:0]            trip_q;

  pa_cfg_regs #(
    .N_SRC(N_SRC), .N_ABORT(N_ABORT), .N_OUT(N_OUT), .TW(TW), .DW(DW),
    .FW(FW), .CW(CW), .TEMP_DEF(TEMP_DEF), .DEW_DEF(DEW_DEF),
    .FLEN_DEF(FLEN_DEF)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .mask_q(mask_q), .tthr_q(tthr_q),
    .dthr_q(dthr_q), .flen_q(flen_q), .route_q(route_q),
    .clr_req(clr_req)
  );

  for (genvar e = 0; e < int'(N_EXT); e++) begin : g_ext
    pa_line_filter #(.FW(FW)) u_flt (
      .clk(clk), .rst_n(rst_n), .line_ok(ext_ok[e]), .flen(flen_q),
      .fault_q(ext_flt[e])
    );
  end

  pa_sensor_cmp #(
    .N_TGRP(N_TGRP), .TCH(TCH), .TW(TW), .DW(DW)
  ) u_sens (
    .clk(clk), .rst_n(rst_n), .temp_data(temp_data), .tthr(tthr_q),
    .dew_data(dew_data), .dthr(dthr_q), .grp_flt_q(grp_flt),
    .dew_flt_q(dew_flt)
  );

  assign src_flt = {dew_flt, grp_flt, ext_flt};

  pa_trip_core #(.N_SRC(N_SRC), .N_OUT(N_OUT), .IW(IW)) u_core (
    .clk(clk), .rst_n(rst_n), .src_flt(src_flt), .mask(mask_q),
    .route(route_q), .clr_req(clr_req), .trip_q(trip_q),
    .ff_valid_q(first_fault_valid), .ff_idx_q(first_fault_idx)
  );

  assign permit = ~trip_q;
endmodule

// File: tb/permit_aggregator_test.sv
`timescale 1ns/1ps
module permit_aggregator_test;
  localparam int N_EXT = 3, N_ABORT = 2, N_TGRP = 2, TCH = 4, TW = 12;
  localparam int DW = 12, FW = 8, N_OUT = 4, N_SRC = 6, IW = 3, CW = 12;
  localparam int NCH = N_TGRP * TCH;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_EXT-1:0] ext_ok;
  logic [NCH*TW-1:0] temp_data;
  logic signed [DW-1:0] dew_data;
  logic cfg_we;
  logic [3:0] cfg_addr;
  logic [CW-1:0] cfg_wdata;
  logic [N_OUT-1:0] permit;
  logic first_fault_valid;
  logic [IW-1:0] first_fault_idx;

  int t_val [NCH];
  int dew_val;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) temp_data[c*TW +: TW] = TW'(t_val[c]);
    dew_data = DW'(dew_val);
  end

  permit_aggregator #(
    .N_EXT(N_EXT), .N_ABORT(N_ABORT), .N_TGRP(N_TGRP), .TCH(TCH), .TW(TW),
    .DW(DW), .FW(FW), .N_PSG(2), .N_SUB(2), .TEMP_DEF(2000),
    .DEW_DEF(-300), .FLEN_DEF(4)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ext_ok(ext_ok), .temp_data(temp_data),
    .dew_data(dew_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .permit(permit),
    .first_fault_valid(first_fault_valid), .first_fault_idx(first_fault_idx)
  );

  // behavioural reference
  logic [N_SRC-1:0] m_mask;
  bit m_unlock;
  int m_tthr, m_dthr, m_flen;
  logic [N_SRC-1:0] m_route [N_OUT];
  bit m_s1 [N_EXT], m_s2 [N_EXT], m_st [N_EXT];
  int m_cnt [N_EXT];
  bit m_grp [N_TGRP];
  bit m_dew;
  logic [N_OUT-1:0] m_trip;
  bit m_ffv;
  int m_ffi;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [N_SRC-1:0] src, en, anyr, blk;
    int lim;
    bit h;
    if (!rst_n) begin
      m_mask = '0; m_unlock = 0; m_tthr = 2000; m_dthr = -300; m_flen = 4;
      for (int k = 0; k < N_OUT; k++) m_route[k] = '1;
      for (int i = 0; i < N_EXT; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_st[i] = 1; m_cnt[i] = 0;
      end
      for (int g = 0; g < N_TGRP; g++) m_grp[g] = 1;
      m_dew = 1; m_trip = '1; m_ffv = 0; m_ffi = 0;
    end else begin
      for (int i = 0; i < N_EXT; i++) src[i] = m_st[i];
      for (int g = 0; g < N_TGRP; g++) src[N_EXT+g] = m_grp[g];
      src[N_SRC-1] = m_dew;
      en = src & ~m_mask;
      anyr = '0;
      for (int k = 0; k < N_OUT; k++) anyr = anyr | m_route[k];
      blk = en & anyr;
      if (cfg_we && cfg_addr == 4'd5 && cfg_wdata[0] && blk == '0) begin
        m_trip = '0; m_ffv = 0;
      end else begin
        for (int k = 0; k < N_OUT; k++) if ((en & m_route[k]) != '0) m_trip[k] = 1'b1;
        if (!m_ffv && blk != '0) begin
          m_ffv = 1;
          for (int i = N_SRC-1; i >= 0; i--) if (blk[i]) m_ffi = i;
        end
      end
      lim = (m_flen == 0) ? 1 : m_flen;
      for (int i = 0; i < N_EXT; i++) begin
        if ((!m_s2[i]) != m_st[i]) begin
          if (m_cnt[i] + 1 >= lim) begin m_st[i] = !m_s2[i]; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end else m_cnt[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = ext_ok[i];
      end
      for (int g = 0; g < N_TGRP; g++) begin
        h = 0;
        for (int c = 0; c < TCH; c++) if (t_val[g*TCH+c] > m_tthr) h = 1;
        m_grp[g] = h;
      end
      m_dew = (dew_val > m_dthr);
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: begin
            m_mask[N_SRC-1:N_ABORT] = cfg_wdata[N_SRC-1:N_ABORT];
            if (m_unlock) m_mask[N_ABORT-1:0] = cfg_wdata[N_ABORT-1:0];
          end
          4'd1: m_unlock = cfg_wdata[0];
          4'd2: m_tthr = int'(cfg_wdata);
          4'd3: m_dthr = int'($signed(cfg_wdata));
          4'd4: m_flen = int'(cfg_wdata[FW-1:0]);
          default: if (cfg_addr >= 4'd8 && cfg_addr < 4'd12)
                     m_route[cfg_addr-4'd8] = cfg_wdata[N_SRC-1:0];
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(permit == ~m_trip, "R1 permit vs model", int'(permit), int'(~m_trip));
      chk(first_fault_valid == m_ffv, "R10 ff valid vs model",
          int'(first_fault_valid), int'(m_ffv));
      chk(int'(first_fault_idx) == m_ffi, "R10 ff index vs model",
          int'(first_fault_idx), m_ffi);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = CW'(d);
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ext_ok = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int c = 0; c < NCH; c++) t_val[c] = 0;
    dew_val = -400;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(permit == 4'h0, "R2 permits low after reset", int'(permit), 0);
    chk(first_fault_valid && first_fault_idx == 3'd0, "R2 reset first fault",
        int'(first_fault_idx), 0);

    ext_ok = 3'b111;
    idle(12);
    wr(5, 1);
    chk(permit == 4'hF, "R9 clear when healthy", int'(permit), 15);

    // short dropout is filtered out
    ext_ok[2] = 1'b0; idle(3); ext_ok[2] = 1'b1; idle(10);
    chk(permit == 4'hF, "R3 three-cycle dropout rejected", int'(permit), 15);
    ext_ok[2] = 1'b0; idle(10);
    chk(permit == 4'h0, "R3 long dropout trips", int'(permit), 0);
    chk(first_fault_idx == 3'd2, "R10 cooling captured", int'(first_fault_idx), 2);
    ext_ok[2] = 1'b1; idle(10); wr(5, 1);
    chk(permit == 4'hF, "R9 clear after recovery", int'(permit), 15);

    // masking
    wr(0, 6'b000100);
    ext_ok[2] = 1'b0; idle(10);
    chk(permit == 4'hF, "R6 masked source ignored", int'(permit), 15);
    ext_ok[2] = 1'b1; idle(10); wr(0, 0);

    // locked abort mask
    wr(0, 6'b000011);
    ext_ok[0] = 1'b0; idle(10);
    chk(permit == 4'h0, "R7 locked abort mask not applied", int'(permit), 0);
    ext_ok[0] = 1'b1; idle(10); wr(5, 1);
    chk(permit == 4'hF, "R9 clear after abort", int'(permit), 15);
    wr(1, 1); wr(0, 6'b000001); wr(1, 0);
    ext_ok[0] = 1'b0; idle(10);
    chk(permit == 4'hF, "R7 unlocked abort mask applied", int'(permit), 15);
    wr(0, 0); idle(3);
    chk(permit == 4'hF, "R7 locked unmask ignored", int'(permit), 15);
    ext_ok[0] = 1'b1; idle(10);
    wr(1, 1); wr(0, 0); wr(1, 0);

    // temperature and routing
    wr(8, 6'b101111); wr(9, 6'b101111);
    t_val[5] = 2000; idle(5);
    chk(permit == 4'hF, "R4 equal to threshold healthy", int'(permit), 15);
    t_val[5] = 2001; idle(5);
    chk(permit == 4'b0011, "R8 partial trip of group 1", int'(permit), 3);
    chk(first_fault_idx == 3'd4, "R4 group 1 captured", int'(first_fault_idx), 4);
    wr(5, 1); idle(2);
    chk(permit == 4'b0011, "R9 clear refused under fault", int'(permit), 3);
    t_val[5] = 0; idle(5); wr(5, 1);
    chk(permit == 4'hF, "R9 clear after cooldown", int'(permit), 15);
    wr(8, 63); wr(9, 63);

    // dew point
    dew_val = -300; idle(5);
    chk(permit == 4'hF, "R5 equal dew threshold healthy", int'(permit), 15);
    dew_val = -299; idle(5);
    chk(permit == 4'h0, "R5 dew above threshold trips", int'(permit), 0);
    chk(first_fault_idx == 3'd5, "R5 dew captured", int'(first_fault_idx), 5);
    ext_ok[1] = 1'b0; idle(10);
    chk(first_fault_idx == 3'd5, "R10 later fault does not overwrite",
        int'(first_fault_idx), 5);
    ext_ok[1] = 1'b1;
    wr(3, -200); idle(10); wr(5, 1);
    chk(permit == 4'hF, "R5 raised threshold then clear", int'(permit), 15);

    // filter length zero acts as one
    wr(4, 0);
    ext_ok[2] = 1'b0; idle(1); ext_ok[2] = 1'b1; idle(8);
    chk(permit == 4'h0, "R3 length zero trips on one cycle", int'(permit), 0);
    chk(first_fault_idx == 3'd2, "R10 one-cycle dropout captured",
        int'(first_fault_idx), 2);
    idle(4);
    finish_run();
  end
endmodule